// File: doc/BRIEF.md
# Pixel-to-Core Clock Domain Bridge

This block carries camera video from the pixel clock of a camera interface into a faster, fixed core clock. Each pixel clock cycle it takes one data word plus three qualifiers: frame-valid, line-valid and data-valid. Every word that arrives with data-valid high is written, with its qualifiers, into one entry of a small dual-clock FIFO. The read and write pointers cross between the two domains as Gray code.

On the core side the bridge drains one entry per core cycle whenever the FIFO holds data. It presents the word together with the frame and line qualifiers that came with it, plus start-of-frame and start-of-line markers. A one-cycle enable strobe goes with each word. Downstream storage writes on that strobe, so each camera word is captured exactly once. The core clock must run faster than the pixel clock. The strobe therefore has gaps whose density follows the clock ratio.

A sticky overflow flag on the core side shows that a word was dropped because the FIFO was full. Only a reset clears it.

Top module: `pxb_bridge`

## Requirements
- R1: Every pixel cycle with `pix_dval` high and the FIFO not full produces exactly one core cycle with `core_en` high. Words come out in arrival order, and `core_data` equals the written word.
- R2: With each strobe, `core_fval` and `core_lval` equal the values of `pix_fval` and `pix_lval` sampled in the same pixel cycle as the word.
- R3: `core_sof` is high with a word when that word had frame-valid high and is the first accepted word since a pixel cycle with frame-valid low. `core_sof` is never high while `core_fval` is low.
- R4: `core_sol` is high with a word when that word had line-valid high and is the first accepted word since a pixel cycle with line-valid low. `core_sol` is never high while `core_lval` is low.
- R5: Pixel cycles with `pix_dval` low transfer nothing, whatever the data and the other qualifiers hold.
- R6: With unbroken data-valid and a pixel clock at 0.8 times the core clock, 200 words give 200 strobes. Over the span from first to last strobe there are between 40 and 60 strobe-free core cycles.
- R7: A single word written into an empty bridge raises `core_en` within 6 core cycles of the pixel edge that wrote it.
- R8: A word that arrives while the FIFO holds DEPTH (default 8) entries is dropped and sets `core_ovf`. `core_ovf` stays high until reset and stays low while no word is dropped.
- R9: During and just after reset, `core_en`, `core_sof`, `core_sol`, `core_fval`, `core_lval` and `core_ovf` are 0 and `core_data` is all zeros.
- R10: Each Gray pointer register changes at most one bit per clock of its own domain, and the FIFO occupancy seen from either side never exceeds DEPTH.
- R11: While `core_en` is low, `core_data` holds the last delivered word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock, slower than core_clk |
| pix_rst | input | 1 | Synchronous active-high reset, pixel domain |
| pix_data | input | DATA_W | Pixel data word |
| pix_fval | input | 1 | Frame-valid qualifier |
| pix_lval | input | 1 | Line-valid qualifier |
| pix_dval | input | 1 | Data-valid; a high cycle offers one word |
| core_clk | input | 1 | Core clock |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| core_en | output | 1 | One-cycle strobe per delivered word |
| core_data | output | DATA_W | Delivered word, held between strobes |
| core_fval | output | 1 | Frame-valid that came with the word |
| core_lval | output | 1 | Line-valid that came with the word |
| core_sof | output | 1 | First word of a frame |
| core_sol | output | 1 | First word of a line |
| core_ovf | output | 1 | Sticky flag: a word was dropped on a full FIFO |

## Verification
Write and read pointers that drift apart show up at the ports as an extra, a missing or a repeated strobe. They also show up as a word compared out of order. This appears on the first word after the fault, within a few core cycles. Framing markers built from a wrong arm state give a wrong start-of-frame or start-of-line count over one frame. A broken full test shows as a wrong strobe count after a stalled core resumes, or as a missing overflow flag. A faulty Gray or synchronizer path most often shows as added latency beyond the bound or as corrupted words under streaming.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

    // Tag carried in every FIFO entry next to the pixel word
    typedef struct packed {
        logic fval;
        logic lval;
        logic sof;
        logic sol;
    } pxb_tag_t;

    localparam int unsigned PXB_TAG_W = $bits(pxb_tag_t);

    // Default number of synchronizer flops on each crossing
    localparam int unsigned PXB_SYNC_STAGES = 2;

endpackage

// File: rtl/pxb_gray_sync.sv
module pxb_gray_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pxb_ram.sv
module pxb_ram #(
    parameter int unsigned W     = 20,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pxb_wr_side.sv
module pxb_wr_side
    import pxb_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1,
    localparam int unsigned EW    = DATA_W + PXB_TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data,
    input  logic              fval,
    input  logic              lval,
    input  logic              dval,
    input  logic [PW-1:0]     rgray_s,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [EW-1:0]     wentry,
    output logic [PW-1:0]     wgray,
    output logic              ovf_tgl
);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used;
    logic          full;
    logic          push;
    logic          drop;
    logic          drop_q;
    logic          frame_arm;
    logic          line_arm;
    pxb_tag_t      tag;

    always_comb begin
        for (int i = 0; i < int'(PW); i++) begin
            rbin_s[i] = ^(rgray_s >> i);
        end
    end

    assign used    = wbin - rbin_s;
    assign full    = used[AW];
    assign push    = dval && !full;
    assign drop    = dval && full;
    assign wbin_nx = wbin + 1'b1;

    always_comb begin
        tag.fval = fval;
        tag.lval = lval;
        tag.sof  = fval && frame_arm;
        tag.sol  = lval && line_arm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin      <= '0;
            wgray     <= '0;
            frame_arm <= 1'b1;
            line_arm  <= 1'b1;
            drop_q    <= 1'b0;
            ovf_tgl   <= 1'b0;
        end else begin
            if (push) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
            if (!fval)     frame_arm <= 1'b1;
            else if (push) frame_arm <= 1'b0;
            if (!lval)     line_arm  <= 1'b1;
            else if (push) line_arm  <= 1'b0;
            drop_q <= drop;
            if (drop && !drop_q) ovf_tgl <= ~ovf_tgl;
        end
    end

    assign we     = push;
    assign waddr  = wbin[AW-1:0];
    assign wentry = {tag, data};

    AST_WR_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);                    // R10

    AST_WR_OCCUPANCY: assert property (@(posedge clk) disable iff (rst)
        used <= PW'(DEPTH));                                       // R10

    AST_WR_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        ($past(used) == PW'(DEPTH) && used == PW'(DEPTH)) |-> $stable(wbin)); // R8

endmodule

// File: rtl/pxb_rd_side.sv
module pxb_rd_side
    import pxb_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1,
    localparam int unsigned EW    = DATA_W + PXB_TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PW-1:0]     wgray_s,
    input  logic [EW-1:0]     rentry,
    input  logic              ovf_tgl_s,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output logic              en,
    output logic [DATA_W-1:0] data,
    output logic              fval,
    output logic              lval,
    output logic              sof,
    output logic              sol,
    output logic              ovf
);

    logic [PW-1:0]     rbin;
    logic [PW-1:0]     rbin_nx;
    logic [PW-1:0]     wbin_s;
    logic              empty;
    logic              tgl_q;
    pxb_tag_t          tag_rd;
    logic [DATA_W-1:0] data_rd;

    always_comb begin
        for (int i = 0; i < int'(PW); i++) begin
            wbin_s[i] = ^(wgray_s >> i);
        end
    end

    assign empty           = (wbin_s == rbin);
    assign rbin_nx         = rbin + 1'b1;
    assign {tag_rd, data_rd} = rentry;
    assign raddr           = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            en    <= 1'b0;
            data  <= '0;
            fval  <= 1'b0;
            lval  <= 1'b0;
            sof   <= 1'b0;
            sol   <= 1'b0;
        end else if (!empty) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            en    <= 1'b1;
            data  <= data_rd;
            fval  <= tag_rd.fval;
            lval  <= tag_rd.lval;
            sof   <= tag_rd.sof;
            sol   <= tag_rd.sol;
        end else begin
            en    <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_q <= ovf_tgl_s;
            ovf   <= 1'b0;
        end else begin
            tgl_q <= ovf_tgl_s;
            if (ovf_tgl_s != tgl_q) ovf <= 1'b1;
        end
    end

    AST_RD_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);                    // R10

    AST_RD_OCCUPANCY: assert property (@(posedge clk) disable iff (rst)
        (wbin_s - rbin) <= PW'(DEPTH));                            // R10

    AST_SOF_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (en && sof) |-> fval);                                     // R3

    AST_SOL_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        (en && sol) |-> lval);                                     // R4

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        !en |-> $stable(data));                                    // R11

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(ovf) |-> ovf);                                       // R8

endmodule

// File: rtl/pxb_bridge.sv
module pxb_bridge
    import pxb_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1,
    localparam int unsigned EW    = DATA_W + PXB_TAG_W
) (
    input  logic              pix_clk,
    input  logic              pix_rst,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_fval,
    input  logic              pix_lval,
    input  logic              pix_dval,
    input  logic              core_clk,
    input  logic              core_rst,
    output logic              core_en,
    output logic [DATA_W-1:0] core_data,
    output logic              core_fval,
    output logic              core_lval,
    output logic              core_sof,
    output logic              core_sol,
    output logic              core_ovf
);

    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [EW-1:0] wentry;
    logic [EW-1:0] rentry;
    logic [PW-1:0] wgray;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] rgray;
    logic [PW-1:0] rgray_s;
    logic          ovf_tgl;
    logic          ovf_tgl_s;

    pxb_wr_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
        .clk     (pix_clk),
        .rst     (pix_rst),
        .data    (pix_data),
        .fval    (pix_fval),
        .lval    (pix_lval),
        .dval    (pix_dval),
        .rgray_s (rgray_s),
        .we      (we),
        .waddr   (waddr),
        .wentry  (wentry),
        .wgray   (wgray),
        .ovf_tgl (ovf_tgl)
    );

    pxb_ram #(.W(EW), .DEPTH(DEPTH)) u_ram (
        .wclk  (pix_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wentry),
        .raddr (raddr),
        .rdata (rentry)
    );

    pxb_gray_sync #(.W(PW), .STAGES(PXB_SYNC_STAGES)) u_sync_w2c (
        .clk (core_clk),
        .rst (core_rst),
        .d   (wgray),
        .q   (wgray_s)
    );

    pxb_gray_sync #(.W(PW), .STAGES(PXB_SYNC_STAGES)) u_sync_c2w (
        .clk (pix_clk),
        .rst (pix_rst),
        .d   (rgray),
        .q   (rgray_s)
    );

    pxb_gray_sync #(.W(1), .STAGES(PXB_SYNC_STAGES)) u_sync_ovf (
        .clk (core_clk),
        .rst (core_rst),
        .d   (ovf_tgl),
        .q   (ovf_tgl_s)
    );

    pxb_rd_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .clk       (core_clk),
        .rst       (core_rst),
        .wgray_s   (wgray_s),
        .rentry    (rentry),
        .ovf_tgl_s (ovf_tgl_s),
        .raddr     (raddr),
        .rgray     (rgray),
        .en        (core_en),
        .data      (core_data),
        .fval      (core_fval),
        .lval      (core_lval),
        .sof       (core_sof),
        .sol       (core_sol),
        .ovf       (core_ovf)
    );

endmodule

// File: tb/pxb_bridge_tb.sv
`timescale 1ns/1ps
module pxb_bridge_tb;

    localparam int DW    = 16;
    localparam int DEPTH = 8;

    logic          pix_clk = 1'b0;
    logic          pix_rst = 1'b1;
    logic [DW-1:0] pix_data = '0;
    logic          pix_fval = 1'b0;
    logic          pix_lval = 1'b0;
    logic          pix_dval = 1'b0;
    logic          core_clk = 1'b0;
    logic          core_rst = 1'b1;
    logic          core_en;
    logic [DW-1:0] core_data;
    logic          core_fval;
    logic          core_lval;
    logic          core_sof;
    logic          core_sol;
    logic          core_ovf;

    pxb_bridge #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .pix_clk   (pix_clk),
        .pix_rst   (pix_rst),
        .pix_data  (pix_data),
        .pix_fval  (pix_fval),
        .pix_lval  (pix_lval),
        .pix_dval  (pix_dval),
        .core_clk  (core_clk),
        .core_rst  (core_rst),
        .core_en   (core_en),
        .core_data (core_data),
        .core_fval (core_fval),
        .core_lval (core_lval),
        .core_sof  (core_sof),
        .core_sol  (core_sol),
        .core_ovf  (core_ovf)
    );

    // 200 MHz core clock, can be paused; pixel clock at 160 MHz
    bit core_run = 1'b1;
    always begin
        #2.5;
        if (core_run) core_clk = ~core_clk;
    end
    always #3.125 pix_clk = ~pix_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // scoreboard and statistics
    logic [DW+3:0] exp_q [$];
    bit            cmp_on = 1'b1;
    bit            farm = 1'b1;
    bit            larm = 1'b1;
    longint        cyc = 0;
    int            en_cnt, sof_cnt, sol_cnt, mis_cnt, hold_err;
    longint        first_idx, last_idx;
    logic [DW-1:0] last_data = '0;

    always @(posedge core_clk) cyc++;

    always @(negedge core_clk) begin
        if (!core_rst) begin
            if (core_en) begin
                en_cnt++;
                if (core_sof) sof_cnt++;
                if (core_sol) sol_cnt++;
                if (en_cnt == 1) first_idx = cyc;
                last_idx = cyc;
                if (cmp_on) begin
                    if (exp_q.size() == 0) begin
                        mis_cnt++;
                    end else begin
                        logic [DW+3:0] e;
                        e = exp_q.pop_front();
                        if (e != {core_fval, core_lval, core_sof, core_sol, core_data}) begin
                            mis_cnt++;
                            $display("mismatch: got %h exp %h",
                                {core_fval, core_lval, core_sof, core_sol, core_data}, e);
                        end
                    end
                end
            end else if (core_data != last_data) begin
                hold_err++;
            end
            last_data = core_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        en_cnt = 0; sof_cnt = 0; sol_cnt = 0; mis_cnt = 0; hold_err = 0;
        first_idx = 0; last_idx = 0;
    endtask

    // one pixel cycle of stimulus plus the bench's own expectation model
    task automatic drive(input logic [DW-1:0] d, input bit f, input bit l, input bit v);
        @(posedge pix_clk);
        #0.5;
        pix_data = d; pix_fval = f; pix_lval = l; pix_dval = v;
        if (v) exp_q.push_back({f, l, f & farm, l & larm, d});
        if (!f)     farm = 1'b1;
        else if (v) farm = 1'b0;
        if (!l)     larm = 1'b1;
        else if (v) larm = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic drain();
        repeat (30) @(posedge core_clk);
        #1;
    endtask

    task automatic do_reset();
        pix_rst = 1'b1; core_rst = 1'b1;
        pix_dval = 1'b0; pix_fval = 1'b0; pix_lval = 1'b0; pix_data = '0;
        repeat (6) @(posedge pix_clk);
        exp_q.delete();
        farm = 1'b1; larm = 1'b1; cmp_on = 1'b1;
        @(negedge core_clk);
        last_data = '0;
        // R9: outputs while reset is still held
        chk(core_en == 0 && core_sof == 0 && core_sol == 0 && core_fval == 0 &&
            core_lval == 0 && core_ovf == 0 && core_data == '0,
            "R9", "outputs in reset", core_en + core_ovf + core_data, 0);
        @(posedge pix_clk); #0.5 pix_rst = 1'b0;
        @(posedge core_clk); #0.5 core_rst = 1'b0;
        clear_stats();
    endtask

    task automatic t_reset_state();
        do_reset();
        repeat (5) @(negedge core_clk);
        chk(core_en == 0 && core_ovf == 0 && core_data == '0, "R9",
            "outputs after reset", core_en + core_ovf, 0);
    endtask

    // two frames, three lines each, with gaps inside lines
    task automatic t_frames();
        clear_stats();
        idle(3);
        for (int fr = 0; fr < 2; fr++) begin
            drive('0, 1'b1, 1'b0, 1'b0);
            for (int ln = 0; ln < 3; ln++) begin
                for (int px = 0; px < 6; px++) begin
                    // pixel index 2 has data-valid low with junk data (R5)
                    drive(DW'(16'hA000 + fr*256 + ln*16 + px), 1'b1, 1'b1, px != 2);
                end
                drive(16'hDEAD, 1'b1, 1'b0, 1'b0);
            end
            idle(2);
        end
        drain();
        chk(mis_cnt == 0, "R1", "word/qualifier mismatches", mis_cnt, 0);   // also R2
        chk(en_cnt == 30, "R5", "strobes for valid words", en_cnt, 30);
        chk(sof_cnt == 2, "R3", "start-of-frame count", sof_cnt, 2);
        chk(sol_cnt == 6, "R4", "start-of-line count", sol_cnt, 6);
        chk(exp_q.size() == 0, "R1", "words still expected", exp_q.size(), 0);
        chk(hold_err == 0, "R11", "data moved without strobe", hold_err, 0);
    endtask

    // qualifiers that change inside a word run: R2 coverage
    task automatic t_qualifiers();
        clear_stats();
        for (int i = 0; i < 16; i++) drive(DW'(i * 37), (i % 5) != 0, (i % 3) != 0, 1'b1);
        idle(2);
        drain();
        chk(mis_cnt == 0, "R2", "qualifiers with words", mis_cnt, 0);
        chk(en_cnt == 16, "R1", "strobe count", en_cnt, 16);
    endtask

    // continuous stream at 0.8 clock ratio
    task automatic t_stream();
        clear_stats();
        for (int i = 0; i < 200; i++) drive(DW'(i ^ 16'h5A5A), 1'b1, 1'b1, 1'b1);
        idle(2);
        drain();
        chk(en_cnt == 200, "R6", "strobes for stream", en_cnt, 200);
        chk(mis_cnt == 0, "R10", "stream intact across crossing", mis_cnt, 0);
        chk((last_idx - first_idx + 1 - 200) >= 40 && (last_idx - first_idx + 1 - 200) <= 60,
            "R6", "strobe-free cycles", last_idx - first_idx + 1 - 200, 50);
        chk(core_ovf == 0, "R8", "no overflow in stream", core_ovf, 0);
        chk(hold_err == 0, "R11", "hold during stream", hold_err, 0);
    endtask

    task automatic t_latency();
        longint t0;
        clear_stats();
        idle(4);
        drive(16'h1234, 1'b1, 1'b1, 1'b1);
        @(posedge pix_clk);
        t0 = cyc;
        #0.5 pix_dval = 1'b0;
        drain();
        chk(en_cnt == 1, "R7", "single word strobes", en_cnt, 1);
        chk(last_idx - t0 >= 1 && last_idx - t0 <= 6, "R7", "latency in core cycles",
            last_idx - t0, 4);
    endtask

    task automatic t_overflow();
        clear_stats();
        cmp_on = 1'b0;
        idle(3);
        @(negedge core_clk);
        core_run = 1'b0;
        for (int i = 0; i < 20; i++) drive(DW'(16'h7700 + i), 1'b1, 1'b1, 1'b1);
        idle(2);
        #1 core_run = 1'b1;
        drain();
        chk(en_cnt == DEPTH, "R8", "words kept on full FIFO", en_cnt, DEPTH);
        chk(last_data == 16'h7707, "R8", "last kept word", last_data, 16'h7707);
        chk(core_ovf == 1, "R8", "overflow flag set", core_ovf, 1);
        idle(10);
        drain();
        chk(core_ovf == 1, "R8", "overflow flag sticky", core_ovf, 1);
        do_reset();
        repeat (4) @(negedge core_clk);
        chk(core_ovf == 0, "R8", "overflow cleared by reset", core_ovf, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #500000;
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        t_reset_state();
        t_frames();
        t_qualifiers();
        t_latency();
        t_stream();
        t_overflow();
        t_frames();
        finish_run();
    end

endmodule